// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds recently used translations from virtual page numbers to physical page numbers. Every entry is searched in parallel. Each entry keeps the tag it was installed under, the physical page number, a valid bit, read and write permission bits and a dirty bit. A lookup presents a virtual address. In the same cycle the block reports a hit and returns the physical address, the two permission bits and the dirty bit. When no entry matches, it reports a miss. The miss tells the surrounding logic to walk the page table.

Once the walk has finished, the result is installed through the fill port. The fill first takes a free slot. When no slot is free, the victim comes from a round-robin pointer or from a free-running shift-register generator, chosen at build time. A store that hits a clean entry marks that entry dirty. The flush input empties the whole array, which is needed when the address space changes.

Top module: `page_xlate_cache`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses, and lkPaddr, lkRead, lkWrite and lkDirty are all zero.
- R2: A lookup whose page number (lkVaddr above bit OFS_W-1) matches a valid entry raises lkHit in the same cycle. In that cycle lkPaddr holds the entry's physical page number in its upper bits and lkVaddr[OFS_W-1:0] in its low OFS_W bits, and lkRead, lkWrite and lkDirty show that entry's bits.
- R3: lkMiss is high exactly when lkValid is high and no valid entry matches. When lkValid is low, lkHit and lkMiss are both low and the data outputs are zero.
- R4: While any entry is invalid, a fill of a new page number takes the lowest-numbered invalid entry. No valid translation is lost until every slot is occupied.
- R5: With round-robin replacement and the array full, successive fills of new page numbers replace entries in the order they were installed, oldest first, and wrap around.
- R6: A fill whose page number is already present rewrites that entry in place. No other entry is evicted and the round-robin pointer does not move.
- R7: A store lookup (lkStore high) that hits an entry with a clear dirty bit sets that bit, and the change is visible from the next cycle. A load lookup leaves the dirty bit unchanged.
- R8: Asserting flush for one cycle invalidates every entry from the next cycle on. It also returns the round-robin pointer to entry 0.
- R9: When flush and fill are high in the same cycle, the flush wins and the fill installs nothing.
- R10: With random replacement and the array full, a fill of a new page number evicts exactly one existing translation, and the new translation hits afterwards.
- R11: A lookup made in the same cycle as a fill sees the array as it was before the fill. The new translation is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lkValid | input | 1 | Lookup request |
| lkStore | input | 1 | Lookup is a store |
| lkVaddr | input | VA_W | Virtual address to translate |
| lkHit | output | 1 | Lookup matched a valid entry |
| lkMiss | output | 1 | Lookup found no entry; a walk is needed |
| lkPaddr | output | PA_W | Translated physical address |
| lkRead | output | 1 | Read permission of the hit entry |
| lkWrite | output | 1 | Write permission of the hit entry |
| lkDirty | output | 1 | Dirty bit of the hit entry, before any update |
| fillValid | input | 1 | Install a translation |
| fillVpn | input | VA_W-OFS_W | Virtual page number to install |
| fillPpn | input | PA_W-OFS_W | Physical page number to install |
| fillRead | input | 1 | Read permission to install |
| fillWrite | input | 1 | Write permission to install |
| fillDirty | input | 1 | Initial dirty bit to install |

## Verification
The corner that is hardest to reach from the ports is replacement in a full array. It needs every slot occupied by a distinct page before a single eviction can happen. The stimulus therefore installs 32 distinct pages and then adds more, one at a time. After each one it sweeps lookups over all installed pages to find the entry that was evicted. The same sweep runs after a flush that coincides with a fill, which shows that the pointer restarted and that the fill was discarded. For random replacement the eviction order is not predicted. The sweep instead counts the surviving translations.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic {
    REPL_FIFO   = 1'b0,
    REPL_RANDOM = 1'b1
  } replPolicy_t;

  // Strobes from control to the entry array
  typedef struct packed {
    logic flushAll;
    logic wrEn;
    logic dirtyEn;
  } xlateStrobe_t;

endpackage

// File: rtl/xlate_array.sv
module xlate_array
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  xlateStrobe_t       strobe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   dirtyIdx,
  input  logic [VPN_W-1:0]   lookVpn,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic               fillRead,
  input  logic               fillWrite,
  input  logic               fillDirty,
  output logic [ENTRIES-1:0] lookMatch,
  output logic [ENTRIES-1:0] fillMatch,
  output logic [ENTRIES-1:0] validVec,
  output logic [PPN_W-1:0]   lookPpn,
  output logic               lookRead,
  output logic               lookWrite,
  output logic               lookDirty
);

  logic [VPN_W-1:0]   tagQ   [ENTRIES];
  logic [PPN_W-1:0]   ppnQ   [ENTRIES];
  logic [ENTRIES-1:0] readVec;
  logic [ENTRIES-1:0] writeVec;
  logic [ENTRIES-1:0] dirtyVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        validVec[i] <= 1'b0;
        readVec[i]  <= 1'b0;
        writeVec[i] <= 1'b0;
        dirtyVec[i] <= 1'b0;
        tagQ[i]     <= '0;
        ppnQ[i]     <= '0;
      end else if (strobe.flushAll) begin
        validVec[i] <= 1'b0;
      end else if (strobe.wrEn && wrIdx == IDX_W'(i)) begin
        validVec[i] <= 1'b1;
        readVec[i]  <= fillRead;
        writeVec[i] <= fillWrite;
        dirtyVec[i] <= fillDirty;
        tagQ[i]     <= fillVpn;
        ppnQ[i]     <= fillPpn;
      end else if (strobe.dirtyEn && dirtyIdx == IDX_W'(i)) begin
        dirtyVec[i] <= 1'b1;
      end
    end

    assign lookMatch[i] = validVec[i] && (tagQ[i] == lookVpn);
    assign fillMatch[i] = validVec[i] && (tagQ[i] == fillVpn);
  end

  // OR-reduce the selected entry; at most one match exists
  always_comb begin
    lookPpn   = '0;
    lookRead  = 1'b0;
    lookWrite = 1'b0;
    lookDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      lookPpn   = lookPpn | ({PPN_W{lookMatch[i]}} & ppnQ[i]);
      lookRead  = lookRead  | (lookMatch[i] & readVec[i]);
      lookWrite = lookWrite | (lookMatch[i] & writeVec[i]);
      lookDirty = lookDirty | (lookMatch[i] & dirtyVec[i]);
    end
  end

  // R6: duplicate tags never arise, so a lookup matches at most one entry
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lookMatch));

  // R8: flush leaves the array empty
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flushAll |=> (validVec == '0));

  // R11: a fill is valid in the following cycle
  p_fill_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && !strobe.flushAll) |=> validVec[$past(wrIdx)]);

  // R7: a store hit marks its entry dirty
  p_dirty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.dirtyEn && !strobe.flushAll && !(strobe.wrEn && wrIdx == dirtyIdx))
      |=> dirtyVec[$past(dirtyIdx)]);

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int          ENTRIES = 32,
  parameter int          IDX_W   = $clog2(ENTRIES),
  parameter replPolicy_t POLICY  = REPL_FIFO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               lkValid,
  input  logic               lkStore,
  input  logic               fillValid,
  input  logic [ENTRIES-1:0] lookMatch,
  input  logic [ENTRIES-1:0] fillMatch,
  input  logic [ENTRIES-1:0] validVec,
  input  logic               lookDirty,
  output xlateStrobe_t       strobe,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [IDX_W-1:0]   dirtyIdx,
  output logic               lookHit
);

  localparam int LFSR_W = 16;

  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] dupIdx;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] policyIdx;
  logic             anyFree;
  logic             dupHit;
  logic             usePolicy;

  always_comb begin
    hitIdx = '0;
    dupIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookMatch[i]) hitIdx = IDX_W'(i);
      if (fillMatch[i]) dupIdx = IDX_W'(i);
    end
  end

  // lowest-numbered free slot wins
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign dupHit    = |fillMatch;
  assign lookHit   = lkValid && (|lookMatch);
  assign usePolicy = fillValid && !flush && !dupHit && !anyFree;

  assign wrIdx    = dupHit ? dupIdx : (anyFree ? freeIdx : policyIdx);
  assign dirtyIdx = hitIdx;

  always_comb begin
    strobe.flushAll = flush;
    strobe.wrEn     = fillValid && !flush;
    strobe.dirtyEn  = lookHit && lkStore && !lookDirty && !flush;
  end

  if (POLICY == REPL_FIFO) begin : g_fifo
    logic [IDX_W-1:0] nextOut;
    always_ff @(posedge clk) begin
      if (!rst_n || flush) nextOut <= '0;
      else if (usePolicy)  nextOut <= nextOut + 1'b1;
    end
    assign policyIdx = nextOut;

    // R5: each eviction moves the pointer by exactly one
    p_fifo_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      usePolicy |=> (nextOut == $past(nextOut) + 1'b1));
  end else begin : g_random
    logic [LFSR_W-1:0] lfsr;
    always_ff @(posedge clk) begin
      if (!rst_n) lfsr <= 16'hACE1;
      else        lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
    end
    assign policyIdx = lfsr[IDX_W-1:0];
  end

  // R4: a free slot is used before any valid entry is replaced
  p_fill_prefers_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fillValid && !flush && !dupHit && anyFree) |-> !validVec[wrIdx]);

endmodule

// File: rtl/page_xlate_cache.sv
module page_xlate_cache
  import xlate_pkg::*;
#(
  parameter int          ENTRIES = 32,
  parameter int          VA_W    = 32,
  parameter int          PA_W    = 32,
  parameter int          OFS_W   = 12,
  parameter replPolicy_t POLICY  = REPL_FIFO
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  lkValid,
  input  logic                  lkStore,
  input  logic [VA_W-1:0]       lkVaddr,
  output logic                  lkHit,
  output logic                  lkMiss,
  output logic [PA_W-1:0]       lkPaddr,
  output logic                  lkRead,
  output logic                  lkWrite,
  output logic                  lkDirty,
  input  logic                  fillValid,
  input  logic [VA_W-OFS_W-1:0] fillVpn,
  input  logic [PA_W-OFS_W-1:0] fillPpn,
  input  logic                  fillRead,
  input  logic                  fillWrite,
  input  logic                  fillDirty
);

  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int IDX_W = $clog2(ENTRIES);

  xlateStrobe_t       strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic [IDX_W-1:0]   dirtyIdx;
  logic [ENTRIES-1:0] lookMatch;
  logic [ENTRIES-1:0] fillMatch;
  logic [ENTRIES-1:0] validVec;
  logic [PPN_W-1:0]   lookPpn;
  logic               lookRead;
  logic               lookWrite;
  logic               lookDirty;
  logic               lookHit;

  xlate_ctrl #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .POLICY(POLICY)
  ) ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lkValid(lkValid), .lkStore(lkStore), .fillValid(fillValid),
    .lookMatch(lookMatch), .fillMatch(fillMatch), .validVec(validVec),
    .lookDirty(lookDirty), .strobe(strobe), .wrIdx(wrIdx),
    .dirtyIdx(dirtyIdx), .lookHit(lookHit)
  );

  xlate_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) array (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrIdx(wrIdx),
    .dirtyIdx(dirtyIdx), .lookVpn(lkVaddr[VA_W-1:OFS_W]),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillRead(fillRead),
    .fillWrite(fillWrite), .fillDirty(fillDirty),
    .lookMatch(lookMatch), .fillMatch(fillMatch), .validVec(validVec),
    .lookPpn(lookPpn), .lookRead(lookRead), .lookWrite(lookWrite),
    .lookDirty(lookDirty)
  );

  assign lkHit   = lookHit;
  assign lkMiss  = lkValid && !lookHit;
  assign lkPaddr = lookHit ? {lookPpn, lkVaddr[OFS_W-1:0]} : '0;
  assign lkRead  = lookHit && lookRead;
  assign lkWrite = lookHit && lookWrite;
  assign lkDirty = lookHit && lookDirty;

endmodule

// File: tb/page_xlate_cache_test.sv
`timescale 1ns/1ps
module page_xlate_cache_test;
  import xlate_pkg::*;

  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lkValid = 1'b0;
  logic        lkStore = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillPpn = '0;
  logic        fillRead = 1'b0;
  logic        fillWrite = 1'b0;
  logic        fillDirty = 1'b0;

  logic        lkHit, lkMiss, lkRead, lkWrite, lkDirty;
  logic [31:0] lkPaddr;
  logic        rHit, rMiss, rRead, rWrite, rDirty;
  logic [31:0] rPaddr;

  int tests = 0;
  int fails = 0;
  bit rndLastHit;

  // behavioural reference state
  bit      mV [N];
  int      mVpn [N];
  int      mPpn [N];
  bit      mR [N];
  bit      mW [N];
  bit      mD [N];
  int      mPtr = 0;

  always #2.5 clk = ~clk;

  page_xlate_cache uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lkValid(lkValid),
    .lkStore(lkStore), .lkVaddr(lkVaddr), .lkHit(lkHit), .lkMiss(lkMiss),
    .lkPaddr(lkPaddr), .lkRead(lkRead), .lkWrite(lkWrite), .lkDirty(lkDirty),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillRead(fillRead), .fillWrite(fillWrite), .fillDirty(fillDirty)
  );

  page_xlate_cache #(.POLICY(REPL_RANDOM)) uutRnd (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lkValid(lkValid),
    .lkStore(lkStore), .lkVaddr(lkVaddr), .lkHit(rHit), .lkMiss(rMiss),
    .lkPaddr(rPaddr), .lkRead(rRead), .lkWrite(rWrite), .lkDirty(rDirty),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillRead(fillRead), .fillWrite(fillWrite), .fillDirty(fillDirty)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive, compare outputs against the model, advance the model.
  task automatic step(input bit lv, input bit st, input logic [31:0] va,
                      input bit fv, input logic [19:0] fvp, input logic [19:0] fpp,
                      input bit fr, input bit fw, input bit fd, input bit fl,
                      input string req);
    int hitI;
    int wi;
    logic [35:0] exp;
    lkValid = lv; lkStore = st; lkVaddr = va;
    fillValid = fv; fillVpn = fvp; fillPpn = fpp;
    fillRead = fr; fillWrite = fw; fillDirty = fd; flush = fl;
    #1;
    hitI = -1;
    for (int i = 0; i < N; i++)
      if (mV[i] && mVpn[i] == int'(va[31:12])) hitI = i;
    if (lv && hitI >= 0)
      exp = {1'b1, 1'b0, mR[hitI], mW[hitI], mPpn[hitI][19:0], va[11:0]};
    else
      exp = {1'b0, lv, 2'b00, 32'h0};
    check(req, {lkHit, lkMiss, lkRead, lkWrite, lkPaddr}, exp);
    if (lv && hitI >= 0)
      check({req, " dirty"}, {35'h0, lkDirty}, {35'h0, mD[hitI]});
    rndLastHit = rHit;
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) mV[i] = 1'b0;
      mPtr = 0;
    end else begin
      wi = -1;
      if (fv) begin
        for (int i = 0; i < N; i++)
          if (mV[i] && mVpn[i] == int'(fvp)) wi = i;
        if (wi < 0)
          for (int i = N - 1; i >= 0; i--)
            if (!mV[i]) wi = i;
        if (wi < 0) begin
          wi = mPtr;
          mPtr = (mPtr + 1) % N;
        end
      end
      if (lv && st && hitI >= 0 && !mD[hitI] && hitI != wi) mD[hitI] = 1'b1;
      if (wi >= 0) begin
        mV[wi] = 1'b1; mVpn[wi] = int'(fvp); mPpn[wi] = int'(fpp);
        mR[wi] = fr; mW[wi] = fw; mD[wi] = fd;
      end
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] va, input bit st, input string req);
    step(1'b1, st, va, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input bit w, input string req);
    step(1'b0, 1'b0, '0, 1'b1, vpn, ppn, 1'b1, w, 1'b0, 1'b0, req);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int rndCount;
    for (int i = 0; i < N; i++) begin
      mV[i] = 0; mVpn[i] = 0; mPpn[i] = 0; mR[i] = 0; mW[i] = 0; mD[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    check("R1 reset outputs", {lkHit, lkMiss, lkRead, lkWrite, lkPaddr}, 36'h0);
    look(32'h0010_0123, 1'b0, "R1 miss after reset");
    look(32'h0000_0000, 1'b0, "R3 miss on empty");

    // R4: fill every slot with distinct pages; R11 lookup of same page misses
    for (int i = 0; i < N; i++) begin
      step(1'b1, 1'b0, {12'h000, 8'h00 + 8'(i), 12'h000} | 32'h0010_0000, 1'b1,
           20'h00100 + 20'(i), 20'h00800 + 20'(i * 3), 1'b1, 1'(i % 2),
           1'b0, 1'b0, "R11 fill then same-cycle lookup");
    end
    for (int i = 0; i < N; i++)
      look({20'h00100 + 20'(i), 12'(i * 37)}, 1'b0, "R4 R2 all installed hit");

    // R3: idle lookup port
    step(1'b0, 1'b0, 32'h0010_0005, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0,
         "R3 no request no hit");

    // R7: store sets dirty, load does not
    look(32'h0010_1abc, 1'b1, "R7 store hit");
    look(32'h0010_1abc, 1'b0, "R7 dirty visible");
    look(32'h0010_2000, 1'b0, "R7 load hit");
    look(32'h0010_2000, 1'b0, "R7 load left clean");

    // R5 / R10: first eviction when full
    fill(20'h00200, 20'h0AAAA, 1'b1, "R5 fill when full");
    rndCount = 0;
    for (int i = 0; i < N; i++) begin
      look({20'h00100 + 20'(i), 12'h010}, 1'b0, "R5 oldest evicted");
      if (rndLastHit) rndCount++;
    end
    look(32'h0020_0044, 1'b0, "R5 new page hits");
    check("R10 random new page hits", {35'h0, rndLastHit}, 36'h1);
    check("R10 random evicts one", 36'(rndCount), 36'(N - 1));

    fill(20'h00201, 20'h0BBBB, 1'b0, "R5 second eviction");
    look(32'h0010_1000, 1'b0, "R5 second oldest gone");
    look(32'h0010_2000, 1'b0, "R5 third still present");

    // R6: duplicate fill rewrites in place
    fill(20'h00105, 20'h0CCCC, 1'b0, "R6 duplicate fill");
    for (int i = 2; i < N; i++)
      look({20'h00100 + 20'(i), 12'h0f0}, 1'b0, "R6 nothing evicted");
    fill(20'h00202, 20'h0DDDD, 1'b1, "R6 pointer unmoved");
    look(32'h0010_2000, 1'b0, "R6 next victim is the oldest");
    look(32'h0010_3000, 1'b0, "R6 following entry kept");

    // R9 / R8: flush beats a simultaneous fill
    step(1'b0, 1'b0, '0, 1'b1, 20'h00300, 20'h0EEEE, 1'b1, 1'b1, 1'b0, 1'b1,
         "R9 flush with fill");
    look(32'h0030_0000, 1'b0, "R9 fill discarded");
    look(32'h0020_0000, 1'b0, "R8 flushed page misses");
    look(32'h0010_3000, 1'b0, "R8 flushed page misses");

    // R8: pointer restarts at entry 0
    for (int i = 0; i < N + 1; i++)
      fill(20'h00400 + 20'(i), 20'h01000 + 20'(i), 1'b0, "R8 refill after flush");
    look(32'h0040_0000, 1'b0, "R8 first refill evicted");
    look(32'h0040_1000, 1'b0, "R8 second refill kept");
    look({20'h00400 + 20'(N), 12'h123}, 1'b0, "R8 last refill hits");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule